// File: doc/BRIEF.md
# Multi-Channel DAC Synchronous Load Controller

This block holds the digital side of a bank of DAC channels. Each channel has three registers: a data register (the staging buffer), an output latch that drives the converter, and a clear-value register. A simple host write port fills these registers. It also sets a per-channel enable mask for synchronous loading and writes a control word. The control word holds a self-clearing load trigger and a global clear bit. Each channel also has an external clear input.

New codes do not reach the converter when the data register is written. They move to the output latches together, on one internal load pulse. The pulse updates only the enabled channels that were written since the last pulse, so a channel that was not written never gets a needless glitch. A clear, from either source, forces the latch to the channel's clear value. The clear does not touch the staged data.

Top module: `dacsl_bank`

## Requirements
- R1: After a synchronous active-low reset, every output code, data register, clear-value register, enable bit and pending-write flag is 0.
- R2: A host write to address 0x00+n stores the code in channel n's data register only. The output code of channel n does not change because of that write.
- R3: A write to the control register (address 0x21) with bit 0 set makes exactly one internal load pulse. This pulse updates the latches on the clock edge that follows the edge that accepted the control write. The output code equals the latch and changes on that same edge.
- R4: The enable mask lives at address 0x20, with bit n for channel n. A load pulse updates channel n only when bit n is 1. A channel with bit n at 0 keeps its latch, and its pending-write flag is kept.
- R5: A load pulse reloads an enabled channel only if its data register was written since the last load that updated that channel. An enabled channel with no such write keeps its latch value.
- R6: A clear sets channel n's latch to its clear-value register (address 0x10+n) on the next clock edge, whatever the enable bit says. There are two clear sources. One is the external input for channel n, which is level-active high. The other is bit 1 of the control register, which clears all channels for as long as it stays set.
- R7: A clear leaves the channel's data register unchanged. A later load of the still-pending data therefore restores the staged code.
- R8: When a clear and a load pulse reach a channel on the same edge, the clear wins. The pending-write flag stays set, so the next load pulse applies the staged data.
- R9: A data write accepted on the same edge as a load pulse does not feed that load. The load uses the code held before the write, and the new code waits as pending for the next pulse.
- R10: The load trigger clears itself. One control write gives one pulse only, and data written afterwards stays staged until another trigger is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 6 | Host write address |
| wr_data | input | max(CODE_W, NUM_CH) | Host write data |
| ext_clr | input | NUM_CH | Per-channel external clear, active high |
| dac_code | output | NUM_CH*CODE_W | Latched codes, channel n at bits [n*CODE_W +: CODE_W] |

## Verification
The hardest case to reach from the ports is a collision on one edge. There is only one write port, so a data write cannot share a cycle with the control write that triggers a load. Because the trigger is registered, the stimulus writes the trigger and then, in the very next cycle, either writes the data register or raises that channel's external clear. That puts the write or the clear on the same edge as the pulse. Pending flags that outlive a disabled pulse or a clear are shown by a later trigger that brings out the staged code.

// File: rtl/dacsl_pkg.sv
// Package: shared address map and control bit positions for the DAC
// synchronous load controller. Assumes at most 16 channels so the data
// and clear-value windows do not overlap.
package dacsl_pkg;
    localparam int ADDR_W       = 6;
    localparam int MAX_CH       = 16;
    localparam int DATA_BASE    = 'h00;
    localparam int CLRV_BASE    = 'h10;
    localparam int EN_ADDR      = 'h20;
    localparam int CTL_ADDR     = 'h21;
    localparam int CTL_TRIG_BIT = 0;
    localparam int CTL_GCLR_BIT = 1;

    // Address of channel ch inside a window starting at base.
    function automatic logic [ADDR_W-1:0] ch_addr(input int base, input int ch);
        return ADDR_W'(base + ch);
    endfunction
endpackage

// File: rtl/dacsl_host_regs.sv
// Module: host write decode plus the shared registers (enable mask,
// registered self-clearing load trigger, global clear bit).
// Assumes one write per cycle and NUM_CH <= WR_W.
module dacsl_host_regs
    import dacsl_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int WR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] clrv_we,
    output logic [NUM_CH-1:0] en_q,
    output logic              load_pulse,
    output logic              gclr_q
);
    logic ctl_hit;
    logic en_hit;
    logic trig_wr;

    assign ctl_hit = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));
    assign en_hit  = wr_en && (wr_addr == ADDR_W'(EN_ADDR));
    assign trig_wr = ctl_hit && wr_data[CTL_TRIG_BIT];

    // Per-channel write strobes for the data and clear-value windows.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
        assign data_we[n] = wr_en && (wr_addr == ch_addr(DATA_BASE, n));
        assign clrv_we[n] = wr_en && (wr_addr == ch_addr(CLRV_BASE, n));
    end

    // Enable mask register, replaced whole on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (en_hit) en_q <= wr_data[NUM_CH-1:0];
    end

    // Trigger is stored for one cycle only, so it reads as 0 afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) load_pulse <= 1'b0;
        else        load_pulse <= trig_wr;
    end

    // Global clear bit holds its value until the control word is rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n)       gclr_q <= 1'b0;
        else if (ctl_hit) gclr_q <= wr_data[CTL_GCLR_BIT];
    end

    AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && !trig_wr) |=> !load_pulse); // R10
    AST_GCLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hit |=> $stable(gclr_q)); // R6
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_hit |=> $stable(en_q)); // R4
endmodule

// File: rtl/dacsl_channel.sv
// Module: one DAC channel holding its staging register, clear-value
// register, pending-write flag and output latch. Assumes clr_i and
// load_i are synchronous. A clear outranks a load on the same edge.
module dacsl_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              clrv_we,
    input  logic [CODE_W-1:0] wdata,
    input  logic              en_i,
    input  logic              load_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] data_q;
    logic [CODE_W-1:0] clrv_q;
    logic [CODE_W-1:0] latch_q;
    logic              dirty_q;
    logic              take;

    // A load applies only to an enabled channel with pending data and no clear.
    assign take = load_i && en_i && dirty_q && !clr_i;

    // Staging register, written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (data_we) data_q <= wdata;
    end

    // Clear-value register, written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       clrv_q <= '0;
        else if (clrv_we) clrv_q <= wdata;
    end

    // Pending flag: a new write sets it, a taken load clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       dirty_q <= 1'b0;
        else if (data_we) dirty_q <= 1'b1;
        else if (take)    dirty_q <= 1'b0;
    end

    // Output latch: a clear comes first, then a taken load.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (clr_i) latch_q <= clrv_q;
        else if (take)  latch_q <= data_q;
    end

    assign code_o = latch_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(load_i && en_i && dirty_q)) |=> $stable(code_o)); // R2
    AST_LOAD_OLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && en_i && dirty_q && !clr_i) |=> (code_o == $past(data_q))); // R9
    AST_DISABLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(code_o)); // R4
    AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (code_o == $past(clrv_q))); // R6
    AST_CLEAR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !data_we) |=> $stable(data_q)); // R7
    AST_CLEAR_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && dirty_q) |=> dirty_q); // R8
    AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && en_i && !clr_i && !data_we) |=> !dirty_q); // R5
endmodule

// File: rtl/dacsl_bank.sv
// Module: top of the DAC synchronous load controller. Builds the host
// register block and NUM_CH channel slices, then merges the external and
// global clears for each channel. Assumes NUM_CH <= 16.
module dacsl_bank
    import dacsl_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int CODE_W = 12,
    localparam int WR_W  = (CODE_W > NUM_CH) ? CODE_W : NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WR_W-1:0]          wr_data,
    input  logic [NUM_CH-1:0]        ext_clr,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] clrv_we;
    logic [NUM_CH-1:0] en_q;
    logic              load_pulse;
    logic              gclr_q;

    // Shared register and decode block.
    dacsl_host_regs #(.NUM_CH(NUM_CH), .WR_W(WR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .data_we    (data_we),
        .clrv_we    (clrv_we),
        .en_q       (en_q),
        .load_pulse (load_pulse),
        .gclr_q     (gclr_q)
    );

    // One channel slice per DAC. Its clear is the external input OR the global bit.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic clr_n;
        assign clr_n = ext_clr[n] | gclr_q;

        dacsl_channel #(.CODE_W(CODE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .data_we (data_we[n]),
            .clrv_we (clrv_we[n]),
            .wdata   (wr_data[CODE_W-1:0]),
            .en_i    (en_q[n]),
            .load_i  (load_pulse),
            .clr_i   (clr_n),
            .code_o  (dac_code[n*CODE_W +: CODE_W])
        );
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0)); // R1
    AST_MAX_CH: assert property (@(posedge clk) NUM_CH <= MAX_CH);
endmodule

// File: tb/test_dacsl_bank.sv
`timescale 1ns/1ps
module test_dacsl_bank;
    localparam int NCH = 12;
    localparam int CW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_addr = '0;
    logic [11:0]     wr_data = '0;
    logic [NCH-1:0]  ext_clr = '0;
    logic [NCH*CW-1:0] dac_code;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    dacsl_bank #(.NUM_CH(NCH), .CODE_W(CW)) i_dacsl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clr(ext_clr), .dac_code(dac_code)
    );

    // Compare one channel's output code with the expected value.
    task automatic chk(input int ch, input logic [11:0] exp, input string req);
        logic [11:0] act;
        act = dac_code[ch*CW +: CW];
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d: actual %h expected %h", req, ch, act, exp);
        end
    endtask

    // One host write, accepted on the next rising edge.
    task automatic wr(input logic [5:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int c = 0; c < NCH; c++) chk(c, 12'h000, "R1");
    endtask

    task automatic t_sync_load;
        wr(6'h20, 12'h023);                 // enable ch0, ch1, ch5
        wr(6'h00, 12'h111); wr(6'h01, 12'h222);
        wr(6'h05, 12'h555); wr(6'h02, 12'h2AA);
        idle(2);
        chk(0, 12'h000, "R2"); chk(5, 12'h000, "R2");
        wr(6'h21, 12'h001);
        chk(0, 12'h000, "R3");              // pulse not yet applied
        idle(1);
        chk(0, 12'h111, "R3"); chk(1, 12'h222, "R3"); chk(5, 12'h555, "R3");
        chk(2, 12'h000, "R4");              // ch2 not enabled
    endtask

    task automatic t_only_written;
        wr(6'h20, 12'h02F);                 // add ch2, ch3
        wr(6'h01, 12'h3C3);
        wr(6'h21, 12'h001); idle(1);
        chk(1, 12'h3C3, "R5"); chk(0, 12'h111, "R5");
        chk(2, 12'h2AA, "R4");              // flag survived the disabled pulse
        // clear ch0, then a load without a write must not restore it
        wr(6'h10, 12'h0F0);
        ext_clr[0] = 1'b1; idle(1); ext_clr[0] = 1'b0;
        chk(0, 12'h0F0, "R6");
        wr(6'h21, 12'h001); idle(1);
        chk(0, 12'h0F0, "R5");
    endtask

    task automatic t_clear;
        wr(6'h03, 12'h777); wr(6'h13, 12'h0AB);
        ext_clr[3] = 1'b1; idle(1); ext_clr[3] = 1'b0;
        chk(3, 12'h0AB, "R6");
        wr(6'h21, 12'h001); idle(1);
        chk(3, 12'h777, "R7");
        wr(6'h19, 12'h9A9);                 // ch9 disabled
        ext_clr[9] = 1'b1; idle(1); ext_clr[9] = 1'b0;
        chk(9, 12'h9A9, "R6");
    endtask

    task automatic t_clear_vs_load;
        wr(6'h20, 12'h03F);                 // add ch4
        wr(6'h04, 12'h444); wr(6'h14, 12'h0C4);
        wr(6'h21, 12'h001);
        ext_clr[4] = 1'b1; idle(1); ext_clr[4] = 1'b0;
        chk(4, 12'h0C4, "R8");
        idle(3);
        chk(4, 12'h0C4, "R8");
        wr(6'h21, 12'h001); idle(1);
        chk(4, 12'h444, "R8");
    endtask

    task automatic t_write_during_load;
        wr(6'h20, 12'h07F);                 // add ch6
        wr(6'h06, 12'h601);
        wr(6'h21, 12'h001);
        wr(6'h06, 12'h602);                 // same edge as the pulse
        chk(6, 12'h601, "R9");
        wr(6'h21, 12'h001); idle(1);
        chk(6, 12'h602, "R9");
    endtask

    task automatic t_single_pulse;
        wr(6'h06, 12'h6FF);
        idle(5);
        chk(6, 12'h602, "R10");
        wr(6'h21, 12'h001); idle(1);
        chk(6, 12'h6FF, "R10");
    endtask

    task automatic t_global_clear;
        wr(6'h20, 12'h47F);                 // add ch10
        wr(6'h1A, 12'hA10); wr(6'h1B, 12'hB11);
        wr(6'h21, 12'h002); idle(1);
        chk(10, 12'hA10, "R6"); chk(11, 12'hB11, "R6");
        chk(1, 12'h000, "R6"); chk(0, 12'h0F0, "R6");
        wr(6'h0A, 12'h0AA);
        wr(6'h21, 12'h003); idle(1);        // load while globally cleared
        chk(10, 12'hA10, "R8");
        wr(6'h21, 12'h000); idle(1);
        chk(10, 12'hA10, "R7");
        wr(6'h21, 12'h001); idle(1);
        chk(10, 12'h0AA, "R7");
    endtask

    // Stimulus: reset, then each scenario in turn.
    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_sync_load;
        t_only_written;
        t_clear;
        t_clear_vs_load;
        t_write_during_load;
        t_single_pulse;
        t_global_clear;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule